// File: doc/BRIEF.md
# Three-Wire Serial Control Port

This block is the write-only control port of a surround audio processor. A host microcontroller drives three slow wires: a serial clock, a data line and a load strobe. The block runs on a fast system clock and brings all three wires through synchronizers. It shifts one data bit in on each serial clock rise. On a strobe rise it takes the newest sixteen bits as a frame. Bit D0 is the first bit sent and D15 the last.

A frame counts only when its two trailing bits carry the device address. Its leading bits then choose a register group: the general operating group, the delay group, the master volume group of one channel, or the trimmer group of a channel pair. The fields of that group are written into a bank of held control registers, which the audio datapath reads directly. For each of the four gain channels (center, left surround, right surround, subwoofer), a registered stage adds master volume, fine step and trimmer into a single attenuation in dB. That sum saturates at 87 dB, and a separate mute flag comes out beside it.

Top module: `tw_ctrl_port`

## Requirements
- R1: One data bit is shifted in on each synchronized rise of `sck_i`. The control registers change only in the cycles that follow a synchronized rise of `req_i`, so serial clocking alone leaves every output as it was.
- R2: A strobe commits the last 16 bits shifted in, with D0 the earliest of those 16. Any bits sent before them are discarded.
- R3: A frame is accepted only when D14 = 0 and D15 = 1. Any other address value leaves all registers unchanged.
- R4: General frame (D0 = D1 = D2 = 0). The mode code is {D4,D5,D6}: 0 multichannel input, 1 stereo bypass, 2 matrix surround, 3 space surround, 4 echo, 5 output mute. Codes 6 and 7 keep the previous mode. The other fields are: D7 selects 3-channel operation; {D8,D9} is the center mode (0 wide, 1 normal, 2 phantom, 3 off); D10 enables auto-balance; D11 enables the noise sequencer; {D12,D13} is the sequencer channel.
- R5: Delay frame (D0 = D1 = 0, D2 = 1). The delay-time index is {D5,D6,D7}, with values 0 to 6 running from shortest to longest; index 7 keeps the previous value. `space_opt_o[k]` takes D(8+k) for k = 0..5.
- R6: Volume frame (D0 = 0, D1 = 1). The channel is {D2,D3}: 0 center, 1 left surround, 2 right surround, 3 subwoofer. The coarse code is D11..D7 with D7 as LSB, and the fine code is {D13,D12}. A center frame also writes the delay volume {D4,D5,D6}. A left-surround frame also writes the feedback volume {D4,D5,D6}. A subwoofer frame also writes `sub_ctl_o` from D6.
- R7: Trimmer frame (D0 = 1, D1 = 0). D8..D4 and D13..D9 are two 5-bit trim codes, each with its lower-numbered bit as LSB. With D2 = 0 they go to center and subwoofer. With D2 = 1 they go to left surround and right surround.
- R8: Coarse codes 0..22 give 2 dB per step. Codes 23..30 give 44 dB plus 4 dB per step above 22. The fine code adds 0..3 dB and the trim code adds 0..31 dB. Channel k's attenuation appears on `att_db_o[7k+6:7k]`.
- R9: When the sum exceeds 87 dB, the attenuation output is exactly 87.
- R10: Coarse code 31 mutes the channel: `att_mute_o[k]` = 1 and the attenuation reads 87, whatever the fine and trim codes are.
- R11: Frames with D0 = D1 = 1 are ignored.
- R12: Reset sets mode 5, coarse 31 (muted) on every channel, delay and feedback volume 7, and all other fields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Asynchronous serial clock |
| data_i | input | 1 | Asynchronous serial data |
| req_i | input | 1 | Asynchronous frame load strobe |
| mode_o | output | 3 | Operating mode code |
| matrix3_o | output | 1 | 3-channel operation select |
| center_o | output | 2 | Center mode |
| autobal_o | output | 1 | Auto-balance enable |
| noise_en_o | output | 1 | Noise sequencer enable |
| noise_ch_o | output | 2 | Noise sequencer channel |
| delay_sel_o | output | 3 | Delay-time index |
| space_opt_o | output | 6 | Space-surround option bits |
| dly_vol_o | output | 3 | Delay volume code |
| fb_vol_o | output | 3 | Feedback volume code |
| sub_ctl_o | output | 1 | Subwoofer volume in circuit (1) or bypassed (0) |
| coarse_o | output | 20 | Coarse volume codes, 5 bits per channel |
| fine_o | output | 8 | Fine volume codes, 2 bits per channel |
| trim_o | output | 20 | Trim codes, 5 bits per channel |
| att_db_o | output | 28 | Combined attenuation in dB, 7 bits per channel |
| att_mute_o | output | 4 | Channel mute flags |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, address {D15,D14} = 2'b10 and an 87 dB floor. It holds each serial wire level for three system clocks, well above the synchronizer delay, so every bit and every strobe is seen exactly once. These settings make several corners reachable with hand-computed values: the 2 dB to 4 dB step change at coarse code 22/23, a sum of 110 dB clipped to 87, a muted channel that carries a nonzero trim, and a strobe arriving after surplus bits or with no new bits at all.

// File: rtl/tw_ctrl_pkg.sv
package tw_ctrl_pkg;
  localparam int FRAME_W  = 16;
  localparam int NCH      = 4;
  localparam int CODE_W   = 5;
  localparam int FINE_W   = 2;
  localparam int TRIM_W   = 5;
  localparam int ATT_W    = 7;
  localparam int SUM_W    = 8;
  localparam int VOL3_W   = 3;
  localparam int OPT_W    = 6;
  localparam int LIN_LAST = 22;   // last coarse code on the 2 dB slope
  localparam logic [CODE_W-1:0] MUTE_CODE = {CODE_W{1'b1}};

  typedef enum logic [2:0] {
    MD_MULTI  = 3'd0,
    MD_BYPASS = 3'd1,
    MD_MATRIX = 3'd2,
    MD_SPACE  = 3'd3,
    MD_ECHO   = 3'd4,
    MD_MUTE   = 3'd5
  } op_mode_t;

  typedef enum logic [1:0] {
    GRP_GEN  = 2'b00,
    GRP_VOL  = 2'b01,
    GRP_TRIM = 2'b10,
    GRP_TEST = 2'b11
  } grp_t;

  // coarse volume code to dB of attenuation (mute code handled by caller)
  function automatic logic [SUM_W-1:0] coarse_db(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] over;
    if (c <= CODE_W'(LIN_LAST)) begin
      return {2'b00, c, 1'b0};
    end
    over = c - CODE_W'(LIN_LAST);
    return SUM_W'(2 * LIN_LAST) + {1'b0, over, 2'b00};
  endfunction
endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tw_frame_cap.sv
module tw_frame_cap
  import tw_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_i,
  input  logic               shift_i,
  input  logic               load_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               vld_o
);
  logic [FRAME_W-1:0] sh_q;

  // newest bit enters at the top; after 16 shifts the first one sits at bit 0
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      frame_o <= '0;
      vld_o   <= 1'b0;
    end else begin
      if (shift_i) sh_q <= {bit_i, sh_q[FRAME_W-1:1]};
      vld_o <= load_i;
      if (load_i) frame_o <= sh_q;
    end
  end
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_ctrl_pkg::*;
#(
  parameter logic [1:0] DEV_ADDR = 2'b10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [FRAME_W-1:0]       f,
  input  logic                     vld,
  output logic [2:0]               mode_o,
  output logic                     matrix3_o,
  output logic [1:0]               center_o,
  output logic                     autobal_o,
  output logic                     noise_en_o,
  output logic [1:0]               noise_ch_o,
  output logic [2:0]               delay_sel_o,
  output logic [OPT_W-1:0]         space_opt_o,
  output logic [VOL3_W-1:0]        dly_vol_o,
  output logic [VOL3_W-1:0]        fb_vol_o,
  output logic                     sub_ctl_o,
  output logic [NCH*CODE_W-1:0]    coarse_o,
  output logic [NCH*FINE_W-1:0]    fine_o,
  output logic [NCH*TRIM_W-1:0]    trim_o
);
  logic [CODE_W-1:0] coarse_q [NCH];
  logic [FINE_W-1:0] fine_q   [NCH];
  logic [TRIM_W-1:0] trim_q   [NCH];

  logic       hit;
  grp_t       grp;
  logic [1:0] vch;
  logic [2:0] mode_code, dsel_code;

  assign hit       = vld && (f[FRAME_W-1 -: 2] == DEV_ADDR);
  assign grp       = grp_t'({f[0], f[1]});
  assign vch       = {f[2], f[3]};
  assign mode_code = {f[4], f[5], f[6]};
  assign dsel_code = {f[5], f[6], f[7]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o      <= MD_MUTE;
      matrix3_o   <= 1'b0;
      center_o    <= '0;
      autobal_o   <= 1'b0;
      noise_en_o  <= 1'b0;
      noise_ch_o  <= '0;
      delay_sel_o <= '0;
      space_opt_o <= '0;
      dly_vol_o   <= '1;
      fb_vol_o    <= '1;
      sub_ctl_o   <= 1'b0;
      for (int k = 0; k < NCH; k++) begin
        coarse_q[k] <= MUTE_CODE;
        fine_q[k]   <= '0;
        trim_q[k]   <= '0;
      end
    end else if (hit) begin
      case (grp)
        GRP_GEN: begin
          if (!f[2]) begin
            if (mode_code <= MD_MUTE) mode_o <= mode_code;
            matrix3_o  <= f[7];
            center_o   <= {f[8], f[9]};
            autobal_o  <= f[10];
            noise_en_o <= f[11];
            noise_ch_o <= {f[12], f[13]};
          end else begin
            if (dsel_code != 3'd7) delay_sel_o <= dsel_code;
            space_opt_o <= f[13:8];
          end
        end
        GRP_VOL: begin
          coarse_q[vch] <= f[11:7];
          fine_q[vch]   <= f[13:12];
          case (vch)
            2'd0:    dly_vol_o <= {f[4], f[5], f[6]};
            2'd1:    fb_vol_o  <= {f[4], f[5], f[6]};
            2'd3:    sub_ctl_o <= f[6];
            default: ;
          endcase
        end
        GRP_TRIM: begin
          if (!f[2]) begin
            trim_q[0] <= f[8:4];
            trim_q[3] <= f[13:9];
          end else begin
            trim_q[1] <= f[8:4];
            trim_q[2] <= f[13:9];
          end
        end
        default: ;  // test group is inhibited
      endcase
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_flat
    assign coarse_o[k*CODE_W +: CODE_W] = coarse_q[k];
    assign fine_o[k*FINE_W +: FINE_W]   = fine_q[k];
    assign trim_o[k*TRIM_W +: TRIM_W]   = trim_q[k];
  end
endmodule

// File: rtl/tw_atten.sv
module tw_atten
  import tw_ctrl_pkg::*;
#(
  parameter int ATT_FLOOR = 87
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH*CODE_W-1:0] coarse_i,
  input  logic [NCH*FINE_W-1:0] fine_i,
  input  logic [NCH*TRIM_W-1:0] trim_i,
  output logic [NCH*ATT_W-1:0]  att_db_o,
  output logic [NCH-1:0]        att_mute_o
);
  localparam logic [SUM_W-1:0] FLOOR_S = SUM_W'(ATT_FLOOR);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [CODE_W-1:0] c;
    logic [SUM_W-1:0]  sum;
    assign c   = coarse_i[k*CODE_W +: CODE_W];
    assign sum = coarse_db(c)
               + SUM_W'(fine_i[k*FINE_W +: FINE_W])
               + SUM_W'(trim_i[k*TRIM_W +: TRIM_W]);

    always_ff @(posedge clk) begin
      if (rst) begin
        att_db_o[k*ATT_W +: ATT_W] <= ATT_W'(ATT_FLOOR);
        att_mute_o[k]              <= 1'b1;
      end else begin
        att_mute_o[k] <= (c == MUTE_CODE);
        if (c == MUTE_CODE || sum > FLOOR_S)
          att_db_o[k*ATT_W +: ATT_W] <= ATT_W'(ATT_FLOOR);
        else
          att_db_o[k*ATT_W +: ATT_W] <= sum[ATT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tw_ctrl_port.sv
module tw_ctrl_port
  import tw_ctrl_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] DEV_ADDR    = 2'b10,
  parameter int         ATT_FLOOR   = 87
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck_i,
  input  logic                  data_i,
  input  logic                  req_i,
  output logic [2:0]            mode_o,
  output logic                  matrix3_o,
  output logic [1:0]            center_o,
  output logic                  autobal_o,
  output logic                  noise_en_o,
  output logic [1:0]            noise_ch_o,
  output logic [2:0]            delay_sel_o,
  output logic [OPT_W-1:0]      space_opt_o,
  output logic [VOL3_W-1:0]     dly_vol_o,
  output logic [VOL3_W-1:0]     fb_vol_o,
  output logic                  sub_ctl_o,
  output logic [NCH*CODE_W-1:0] coarse_o,
  output logic [NCH*FINE_W-1:0] fine_o,
  output logic [NCH*TRIM_W-1:0] trim_o,
  output logic [NCH*ATT_W-1:0]  att_db_o,
  output logic [NCH-1:0]        att_mute_o
);
  logic sck_lvl, sck_rise, dat_lvl, dat_rise, req_lvl, req_rise;
  logic [FRAME_W-1:0] frame_q;
  logic               frame_vld;

  tw_sync_edge #(.STAGES(SYNC_STAGES)) u_sck (
    .clk(clk), .rst(rst), .async_i(sck_i), .level_o(sck_lvl), .rise_o(sck_rise));
  tw_sync_edge #(.STAGES(SYNC_STAGES)) u_dat (
    .clk(clk), .rst(rst), .async_i(data_i), .level_o(dat_lvl), .rise_o(dat_rise));
  tw_sync_edge #(.STAGES(SYNC_STAGES)) u_req (
    .clk(clk), .rst(rst), .async_i(req_i), .level_o(req_lvl), .rise_o(req_rise));

  tw_frame_cap u_cap (
    .clk(clk), .rst(rst), .bit_i(dat_lvl), .shift_i(sck_rise), .load_i(req_rise),
    .frame_o(frame_q), .vld_o(frame_vld));

  tw_reg_bank #(.DEV_ADDR(DEV_ADDR)) u_bank (
    .clk(clk), .rst(rst), .f(frame_q), .vld(frame_vld),
    .mode_o(mode_o), .matrix3_o(matrix3_o), .center_o(center_o),
    .autobal_o(autobal_o), .noise_en_o(noise_en_o), .noise_ch_o(noise_ch_o),
    .delay_sel_o(delay_sel_o), .space_opt_o(space_opt_o),
    .dly_vol_o(dly_vol_o), .fb_vol_o(fb_vol_o), .sub_ctl_o(sub_ctl_o),
    .coarse_o(coarse_o), .fine_o(fine_o), .trim_o(trim_o));

  tw_atten #(.ATT_FLOOR(ATT_FLOOR)) u_att (
    .clk(clk), .rst(rst), .coarse_i(coarse_o), .fine_i(fine_o), .trim_i(trim_o),
    .att_db_o(att_db_o), .att_mute_o(att_mute_o));

  // level outputs of the strobe/clock paths and the data edge are not needed
  logic unused_ok;
  assign unused_ok = ^{sck_lvl, dat_rise, req_lvl};
endmodule

// File: rtl/tw_ctrl_port_chk.sv
module tw_ctrl_port_chk
  import tw_ctrl_pkg::*;
#(
  parameter int ATT_FLOOR = 87
) (
  input logic                  clk,
  input logic                  rst,
  input logic [FRAME_W-1:0]    frame_q,
  input logic                  frame_vld,
  input logic [2:0]            mode_o,
  input logic [2:0]            delay_sel_o,
  input logic [VOL3_W-1:0]     dly_vol_o,
  input logic [VOL3_W-1:0]     fb_vol_o,
  input logic [NCH*CODE_W-1:0] coarse_o,
  input logic [NCH*TRIM_W-1:0] trim_o,
  input logic [NCH*ATT_W-1:0]  att_db_o,
  input logic [NCH-1:0]        att_mute_o
);
  assert_reset_mode_R12: assert property (@(posedge clk)
    rst |=> (mode_o == 3'd5 && dly_vol_o == 3'd7 && fb_vol_o == 3'd7));

  assert_hold_no_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !frame_vld |=> ($stable(mode_o) && $stable(coarse_o) && $stable(trim_o)));

  assert_foreign_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && frame_q[15:14] != 2'b10) |=>
      ($stable(mode_o) && $stable(coarse_o) && $stable(trim_o) && $stable(delay_sel_o)));

  assert_test_group_R11: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && frame_q[1:0] == 2'b11) |=>
      ($stable(mode_o) && $stable(coarse_o) && $stable(trim_o) && $stable(fb_vol_o)));

  assert_mode_legal_R4: assert property (@(posedge clk) disable iff (rst)
    mode_o <= 3'd5);

  assert_delay_legal_R5: assert property (@(posedge clk) disable iff (rst)
    delay_sel_o != 3'd7);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assert_att_floor_R9: assert property (@(posedge clk) disable iff (rst)
      att_db_o[k*ATT_W +: ATT_W] <= ATT_W'(ATT_FLOOR));
    assert_mute_reads_floor_R10: assert property (@(posedge clk) disable iff (rst)
      att_mute_o[k] |-> att_db_o[k*ATT_W +: ATT_W] == ATT_W'(ATT_FLOOR));
  end
endmodule

bind tw_ctrl_port tw_ctrl_port_chk #(.ATT_FLOOR(ATT_FLOOR)) u_chk (
  .clk(clk), .rst(rst), .frame_q(frame_q), .frame_vld(frame_vld),
  .mode_o(mode_o), .delay_sel_o(delay_sel_o), .dly_vol_o(dly_vol_o),
  .fb_vol_o(fb_vol_o), .coarse_o(coarse_o), .trim_o(trim_o),
  .att_db_o(att_db_o), .att_mute_o(att_mute_o));

// File: tb/sim_tw_ctrl_port.sv
module sim_tw_ctrl_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, dat = 1'b0, req = 1'b0;

  logic [2:0]  mode_o, delay_sel_o, dly_vol_o, fb_vol_o;
  logic        matrix3_o, autobal_o, noise_en_o, sub_ctl_o;
  logic [1:0]  center_o, noise_ch_o;
  logic [5:0]  space_opt_o;
  logic [19:0] coarse_o, trim_o;
  logic [7:0]  fine_o;
  logic [27:0] att_db_o;
  logic [3:0]  att_mute_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tw_ctrl_port u0 (
    .clk(clk), .rst(rst), .sck_i(sck), .data_i(dat), .req_i(req),
    .mode_o(mode_o), .matrix3_o(matrix3_o), .center_o(center_o),
    .autobal_o(autobal_o), .noise_en_o(noise_en_o), .noise_ch_o(noise_ch_o),
    .delay_sel_o(delay_sel_o), .space_opt_o(space_opt_o),
    .dly_vol_o(dly_vol_o), .fb_vol_o(fb_vol_o), .sub_ctl_o(sub_ctl_o),
    .coarse_o(coarse_o), .fine_o(fine_o), .trim_o(trim_o),
    .att_db_o(att_db_o), .att_mute_o(att_mute_o));

  // {frame[15:0], probe[3:0], req[3:0], expected[7:0]}
  // probes: 0 mode 1 3ch 2 center 3 autobal 4 {noise en,ch} 5 delay idx 6 options
  //         7 delay vol 8 feedback vol 9..12 {mute,att} of channel 0..3 13 sub ctl
  localparam int NV = 31;
  localparam logic [31:0] VEC [NV] = '{
    {16'hBDA0, 4'd0,  4'd4,  8'h02},  // R4 matrix surround mode
    {16'hBDA0, 4'd1,  4'd4,  8'h01},  // R4 3-channel bit
    {16'hBDA0, 4'd2,  4'd4,  8'h02},  // R4 phantom center
    {16'hBDA0, 4'd3,  4'd4,  8'h01},  // R4 auto-balance
    {16'hBDA0, 4'd4,  4'd4,  8'h07},  // R4 noise on, channel 3
    {16'hBDA0, 4'd0,  4'd4,  8'h02},  // R4 resend
    {16'h8210, 4'd0,  4'd4,  8'h04},  // R4 echo
    {16'h8210, 4'd2,  4'd4,  8'h01},  // R4 normal center
    {16'h8210, 4'd4,  4'd4,  8'h00},  // R4 noise off
    {16'hC020, 4'd0,  4'd3,  8'h04},  // R3 address 11 ignored
    {16'h0020, 4'd0,  4'd3,  8'h04},  // R3 address 00 ignored
    {16'h4020, 4'd0,  4'd3,  8'h04},  // R3 address swapped ignored
    {16'h8030, 4'd0,  4'd4,  8'h04},  // R4 code 6 keeps mode
    {16'h8030, 4'd2,  4'd4,  8'h00},  // R4 other fields still written
    {16'hA564, 4'd5,  4'd5,  8'h06},  // R5 longest delay
    {16'hA564, 4'd6,  4'd5,  8'h25},  // R5 options
    {16'h80E4, 4'd5,  4'd5,  8'h06},  // R5 index 7 keeps delay
    {16'h80E4, 4'd6,  4'd5,  8'h00},  // R5 options cleared
    {16'h8062, 4'd7,  4'd6,  8'h03},  // R6 delay volume via center frame
    {16'h8062, 4'd9,  4'd8,  8'h00},  // R8 center 0 dB
    {16'hABDA, 4'd8,  4'd6,  8'h05},  // R6 feedback via left-surround frame
    {16'hABDA, 4'd10, 4'd8,  8'h32},  // R8 code 23 -> 48 + fine 2
    {16'h8FCE, 4'd13, 4'd6,  8'h01},  // R6 sub control
    {16'h8FCE, 4'd12, 4'd10, 8'hD7},  // R10 sub muted
    {16'hBF06, 4'd11, 4'd8,  8'h4F},  // R8 code 30 -> 76 + 3
    {16'hBF45, 4'd11, 4'd9,  8'h57},  // R9 110 dB clipped to 87
    {16'hBF45, 4'd10, 4'd7,  8'h46},  // R7 left-surround trim 20
    {16'h8251, 4'd9,  4'd7,  8'h05},  // R7 center trim 5
    {16'h8251, 4'd12, 4'd10, 8'hD7},  // R10 trim does not lift mute
    {16'h8FC3, 4'd9,  4'd11, 8'h05},  // R11 test group ignored
    {16'h8B02, 4'd9,  4'd8,  8'h31}   // R8 code 22 -> 44 + trim 5
  };

  function automatic logic [7:0] probe(input logic [3:0] p);
    case (p)
      4'd0:  return {5'd0, mode_o};
      4'd1:  return {7'd0, matrix3_o};
      4'd2:  return {6'd0, center_o};
      4'd3:  return {7'd0, autobal_o};
      4'd4:  return {5'd0, noise_en_o, noise_ch_o};
      4'd5:  return {5'd0, delay_sel_o};
      4'd6:  return {2'd0, space_opt_o};
      4'd7:  return {5'd0, dly_vol_o};
      4'd8:  return {5'd0, fb_vol_o};
      4'd9:  return {att_mute_o[0], att_db_o[6:0]};
      4'd10: return {att_mute_o[1], att_db_o[13:7]};
      4'd11: return {att_mute_o[2], att_db_o[20:14]};
      4'd12: return {att_mute_o[3], att_db_o[27:21]};
      default: return {7'd0, sub_ctl_o};
    endcase
  endfunction

  task automatic check(input int rq, input logic [3:0] p, input logic [7:0] exp);
    logic [7:0] got;
    got = probe(p);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d probe %0d: got %h expected %h", rq, p, got, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) dat = b;
    repeat (3) @(negedge clk);
    sck = 1'b1;
    repeat (3) @(negedge clk);
    sck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) req = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] f);
    for (int i = 0; i < 16; i++) send_bit(f[i]);
    strobe();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(12, 4'd0, 8'h05);
    check(12, 4'd7, 8'h07);
    check(12, 4'd8, 8'h07);
    for (int k = 0; k < 4; k++) check(12, 4'(9 + k), 8'hD7);

    for (int i = 0; i < NV; i++) begin
      send_frame(VEC[i][31:16]);
      check(int'(VEC[i][11:8]), VEC[i][15:12], VEC[i][7:0]);
    end

    // R2 surplus leading bits are dropped: five 1s then a matrix-mode frame
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_frame(16'h8020);
    check(2, 4'd0, 8'h02);

    // R1 clocking bits without a strobe changes nothing
    for (int i = 0; i < 16; i++) send_bit(16'h8010 >> i);
    check(1, 4'd0, 8'h02);
    // R1 a bare strobe then commits what was shifted in
    strobe();
    check(1, 4'd0, 8'h04);

    // R12 reset during operation restores defaults
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(12, 4'd0, 8'h05);
    check(12, 4'd9, 8'hD7);
    check(12, 4'd13, 8'h00);

    finish_run();
  end
endmodule